// File: doc/BRIEF.md
# Four-Phase Ready Handshake Link

This block pairs a sending side and a receiving side that move one data word per transaction over a mutual four-phase handshake. Each side owns a single ready flag. The receiving side arms first by raising its flag. The sending side raises its own flag only once it sees that, then samples its source word onto an internal link bus. The receiving side copies the bus into its capture register and drops its flag. The sending side then drops its flag, and the receiving side re-arms once it has seen that fall. Every state change on either side waits for a level that the other side drives, so neither side can run ahead of the other.

Each side holds each of its states for a programmable minimum number of cycles (1 to 15, with 0 read as 1). Different settings on the two sides change how their sequences interleave, and the word stream stays intact under every setting. A level enable gates the start of new transactions on the sending side. The captured word and a one-cycle valid pulse are the result. Both ready flags are brought out so that the order of the handshake can be watched at the ports.

Top module: `fp_handshake_link`

## Requirements
- R1: A synchronous active-high reset forces both ready flags low, the valid pulse low and the captured word to zero after one clock edge, including when the reset lands in the middle of a transfer.
- R2: The sending flag rises only in a cycle in which the receiving flag is already high, and the receiving flag rises only in a cycle in which the sending flag is low.
- R3: The sending side samples the source word into the link bus as it leaves its wait state. The bus then stays unchanged until the word is captured, and the captured value equals the bus.
- R4: The receiving side captures only after it has seen the sending flag high on two consecutive cycles. The valid pulse lasts exactly one cycle, and in that cycle the receiving flag has just fallen while the sending flag is still high.
- R5: The sending flag falls only while the receiving flag is low.
- R6: With the enable held high, every source word is captured exactly once and in the order it was offered, for any pair of hold settings.
- R7: With hold settings Hs and Hc (0 read as 1), every pulse of the receiving flag lasts at least 2·Hc cycles, every pulse of the sending flag lasts at least Hs+1 cycles, and every low gap of the sending flag between two transactions lasts at least 2·Hs cycles.
- R8: While the enable is low, no new transaction starts: the sending flag stays low and no valid pulse appears. The receiving side still arms. Raising the enable resumes the transfers.
- R9: The data width is a parameter. An 8-bit build carries full 8-bit words with the same timing as the default 4-bit build.
- R10: A hold setting of 0 behaves exactly like a hold setting of 1, cycle for cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Level enable for starting new transactions |
| src_word | input | DATA_W | Word offered to the sending side |
| srv_hold | input | HOLD_W | Minimum cycles per state, sending side |
| cli_hold | input | HOLD_W | Minimum cycles per state, receiving side |
| cap_word | output | DATA_W | Last captured word |
| cap_valid | output | 1 | One-cycle pulse when a word is captured |
| srv_rdy | output | 1 | Sending side ready flag |
| cli_rdy | output | 1 | Receiving side ready flag |

## Verification
A wrong state on either side shows up at the ports within one transaction. If a side gets stuck, valid pulses stop, and a capture timeout exposes it. A side that skips ahead breaks the rise and fall order of the two flags in the same cycle it happens. A capture taken too early yields the previous word or a repeated one, which the in-order scoreboard sees at the very next valid pulse. A wrong hold count shortens a flag pulse or gap below its minimum, which is measured directly on the flags.

// File: rtl/fp_link_pkg.sv
package fp_link_pkg;

  typedef enum logic [1:0] {
    SV_IDLE  = 2'd0,
    SV_WAIT  = 2'd1,
    SV_SERVE = 2'd2,
    SV_DONE  = 2'd3
  } srv_state_t;

  typedef enum logic [1:0] {
    CL_IDLE  = 2'd0,
    CL_READY = 2'd1,
    CL_WAIT  = 2'd2,
    CL_DONE  = 2'd3
  } cli_state_t;

endpackage

// File: rtl/fp_hold_timer.sv
// Counts cycles spent in the current state; met goes high on the cycle
// in which the programmed minimum has been reached (0 is read as 1).
module fp_hold_timer #(
  parameter int HOLD_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic [HOLD_W-1:0] hold,
  output logic              met
);
  localparam logic [HOLD_W-1:0] ONE = HOLD_W'(1);

  logic [HOLD_W-1:0] cnt;
  logic [HOLD_W-1:0] last;

  assign last = (hold == '0) ? '0 : (hold - ONE);
  assign met  = (cnt >= last);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt <= '0;
    end else if (!met) begin
      cnt <= cnt + ONE;
    end
  end
endmodule

// File: rtl/fp_sticky.sv
// Remembers that a condition was seen since the last clear; the current
// cycle's condition counts at once.
module fp_sticky (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic cond,
  output logic seen
);
  logic held;

  assign seen = held | cond;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      held <= 1'b0;
    end else begin
      held <= seen;
    end
  end
endmodule

// File: rtl/fp_link_server.sv
module fp_link_server
  import fp_link_pkg::*;
#(
  parameter int DATA_W = 4,
  parameter int HOLD_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [HOLD_W-1:0] hold,
  input  logic [DATA_W-1:0] src_word,
  input  logic              peer_rdy,
  output logic              rdy,
  output logic [DATA_W-1:0] bus
);
  srv_state_t st, st_nx;
  logic met;
  logic low_seen;
  logic moving;
  logic launch;

  assign moving = (st_nx != st);
  assign launch = (st == SV_WAIT) && (st_nx == SV_SERVE);

  fp_hold_timer #(.HOLD_W(HOLD_W)) u_hold (
    .clk     (clk),
    .rst     (rst),
    .restart (moving),
    .hold    (hold),
    .met     (met)
  );

  // client flag seen low since entering the current state
  fp_sticky u_low (
    .clk   (clk),
    .rst   (rst),
    .clear (moving),
    .cond  (!peer_rdy),
    .seen  (low_seen)
  );

  always_comb begin
    st_nx = st;
    case (st)
      SV_IDLE:  if (met && go && peer_rdy) st_nx = SV_WAIT;
      SV_WAIT:  if (peer_rdy)              st_nx = SV_SERVE;
      SV_SERVE: if (met && low_seen)       st_nx = SV_DONE;
      SV_DONE:  if (met && low_seen)       st_nx = SV_IDLE;
      default:                             st_nx = SV_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= SV_IDLE;
      rdy <= 1'b0;
      bus <= '0;
    end else begin
      st  <= st_nx;
      rdy <= (st_nx == SV_WAIT) || (st_nx == SV_SERVE);
      if (launch) begin
        bus <= src_word;
      end
    end
  end
endmodule

// File: rtl/fp_link_client.sv
module fp_link_client
  import fp_link_pkg::*;
#(
  parameter int DATA_W = 4,
  parameter int HOLD_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [HOLD_W-1:0] hold,
  input  logic              peer_rdy,
  input  logic [DATA_W-1:0] bus_in,
  output logic              rdy,
  output logic [DATA_W-1:0] word,
  output logic              valid
);
  cli_state_t st, st_nx;
  logic met;
  logic low_seen;
  logic moving;
  logic latch;
  logic peer_q;

  assign moving = (st_nx != st);
  assign latch  = (st == CL_WAIT) && (st_nx == CL_DONE);

  fp_hold_timer #(.HOLD_W(HOLD_W)) u_hold (
    .clk     (clk),
    .rst     (rst),
    .restart (moving),
    .hold    (hold),
    .met     (met)
  );

  // server flag seen low since entering the current state
  fp_sticky u_low (
    .clk   (clk),
    .rst   (rst),
    .clear (moving),
    .cond  (!peer_rdy),
    .seen  (low_seen)
  );

  always_comb begin
    st_nx = st;
    case (st)
      CL_IDLE:  if (met)                       st_nx = CL_READY;
      CL_READY: if (met)                       st_nx = CL_WAIT;
      CL_WAIT:  if (met && peer_rdy && peer_q) st_nx = CL_DONE;
      CL_DONE:  if (met && low_seen)           st_nx = CL_READY;
      default:                                 st_nx = CL_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= CL_IDLE;
      rdy    <= 1'b0;
      word   <= '0;
      valid  <= 1'b0;
      peer_q <= 1'b0;
    end else begin
      st     <= st_nx;
      rdy    <= (st_nx == CL_READY) || (st_nx == CL_WAIT);
      valid  <= latch;
      peer_q <= peer_rdy;
      if (latch) begin
        word <= bus_in;
      end
    end
  end
endmodule

// File: rtl/fp_handshake_link.sv
module fp_handshake_link #(
  parameter int DATA_W = 4,
  parameter int HOLD_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [DATA_W-1:0] src_word,
  input  logic [HOLD_W-1:0] srv_hold,
  input  logic [HOLD_W-1:0] cli_hold,
  output logic [DATA_W-1:0] cap_word,
  output logic              cap_valid,
  output logic              srv_rdy,
  output logic              cli_rdy
);
  logic [DATA_W-1:0] link_bus;

  fp_link_server #(.DATA_W(DATA_W), .HOLD_W(HOLD_W)) u_srv (
    .clk      (clk),
    .rst      (rst),
    .go       (go),
    .hold     (srv_hold),
    .src_word (src_word),
    .peer_rdy (cli_rdy),
    .rdy      (srv_rdy),
    .bus      (link_bus)
  );

  fp_link_client #(.DATA_W(DATA_W), .HOLD_W(HOLD_W)) u_cli (
    .clk      (clk),
    .rst      (rst),
    .hold     (cli_hold),
    .peer_rdy (srv_rdy),
    .bus_in   (link_bus),
    .rdy      (cli_rdy),
    .word     (cap_word),
    .valid    (cap_valid)
  );
endmodule

// File: rtl/fp_link_checker.sv
module fp_link_checker #(
  parameter int DATA_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              srv_rdy,
  input logic              cli_rdy,
  input logic              cap_valid,
  input logic [DATA_W-1:0] link_bus,
  input logic [DATA_W-1:0] cap_word
);

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!srv_rdy && !cli_rdy && !cap_valid));

  assert_srv_rise_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(srv_rdy) |-> cli_rdy);

  assert_cli_rise_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(cli_rdy) |-> !srv_rdy);

  assert_bus_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (srv_rdy && !cli_rdy) |-> $stable(link_bus));

  assert_capture_match_R3: assert property (@(posedge clk) disable iff (rst)
    cap_valid |-> (cap_word == link_bus));

  assert_valid_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    cap_valid |=> !cap_valid);

  assert_valid_context_R4: assert property (@(posedge clk) disable iff (rst)
    cap_valid |-> (srv_rdy && $fell(cli_rdy)));

  assert_release_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(srv_rdy) |-> !cli_rdy);

endmodule

bind fp_handshake_link fp_link_checker #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .srv_rdy   (srv_rdy),
  .cli_rdy   (cli_rdy),
  .cap_valid (cap_valid),
  .link_bus  (link_bus),
  .cap_word  (cap_word)
);

// File: tb/sim_fp_handshake_link.sv
`timescale 1ns/1ps
module sim_fp_handshake_link;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       go  = 1'b0;
  logic [3:0] src_w = 4'd0;
  logic [3:0] sh = 4'd1;
  logic [3:0] ch = 4'd1;
  logic [7:0] src_w8;
  logic [3:0] cap_word;
  logic [7:0] cap_word8;
  logic       cap_valid, cap_valid8, srv_rdy, cli_rdy, srv_rdy8, cli_rdy8;

  assign src_w8 = {src_w ^ 4'hA, src_w};

  always #4 clk = ~clk;

  fp_handshake_link u0 (
    .clk(clk), .rst(rst), .go(go), .src_word(src_w), .srv_hold(sh), .cli_hold(ch),
    .cap_word(cap_word), .cap_valid(cap_valid), .srv_rdy(srv_rdy), .cli_rdy(cli_rdy)
  );

  fp_handshake_link #(.DATA_W(8)) u1 (
    .clk(clk), .rst(rst), .go(go), .src_word(src_w8), .srv_hold(sh), .cli_hold(ch),
    .cap_word(cap_word8), .cap_valid(cap_valid8), .srv_rdy(srv_rdy8), .cli_rdy(cli_rdy8)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic logic [3:0] wexp(input int k);
    return 4'((k * 7 + 3) % 16);
  endfunction

  // flag monitor, cleared by reset
  int min_srv_lo, min_srv_hi, min_cli_hi, srv_lo, srv_hi, cli_hi;
  int order_err, rel_err, timing_err, cap_seen;
  bit p_srv, p_cli, p_val, had_fall;

  always @(negedge clk) begin
    if (rst) begin
      min_srv_lo = 1000; min_srv_hi = 1000; min_cli_hi = 1000;
      srv_lo = 0; srv_hi = 0; cli_hi = 0;
      order_err = 0; rel_err = 0; timing_err = 0; cap_seen = 0;
      p_srv = 0; p_cli = 0; p_val = 0; had_fall = 0;
    end else begin
      if (srv_rdy) begin
        if (!p_srv) begin
          if (had_fall && srv_lo < min_srv_lo) min_srv_lo = srv_lo;
          if (!cli_rdy) order_err++;
          srv_hi = 0;
        end
        srv_hi++;
      end else begin
        if (p_srv) begin
          if (srv_hi < min_srv_hi) min_srv_hi = srv_hi;
          if (cli_rdy) rel_err++;
          had_fall = 1;
          srv_lo = 0;
        end
        srv_lo++;
      end
      if (cli_rdy) begin
        if (!p_cli) begin
          if (srv_rdy) order_err++;
          cli_hi = 0;
        end
        cli_hi++;
      end else if (p_cli && cli_hi < min_cli_hi) begin
        min_cli_hi = cli_hi;
      end
      if (cap_valid) begin
        cap_seen++;
        if (p_val || !srv_rdy || cli_rdy || srv_hi < 3) timing_err++;
      end
      p_srv = srv_rdy; p_cli = cli_rdy; p_val = cap_valid;
    end
  end

  task automatic do_reset();
    rst = 1'b1;
    go  = 1'b0;
    repeat (3) @(negedge clk);
    chk(srv_rdy == 1'b0 && cli_rdy == 1'b0, "R1 flags low in reset", {srv_rdy, cli_rdy}, 0);
    chk(cap_valid == 1'b0 && cap_valid8 == 1'b0, "R1 valid low in reset", cap_valid, 0);
    chk(cap_word == 4'd0 && cap_word8 == 8'd0, "R1 word cleared in reset", cap_word, 0);
    rst = 1'b0;
  endtask

  task automatic run_words(input int n, input logic [3:0] shv, input logic [3:0] chv,
                           output int cyc);
    int effs = (shv == 0) ? 1 : int'(shv);
    int effc = (chv == 0) ? 1 : int'(chv);
    bit timed_out = 0;
    do_reset();
    sh = shv; ch = chv;
    src_w = wexp(0);
    go = 1'b1;
    cyc = 0;
    for (int k = 0; k < n && !timed_out; k++) begin
      int w = 0;
      do begin
        @(negedge clk);
        cyc++; w++;
      end while (!cap_valid && w < 600);
      if (!cap_valid) begin
        timed_out = 1;
        chk(0, "R6 capture timeout", w, 600);
      end else begin
        chk(cap_word == wexp(k), "R3 R6 word order", cap_word, wexp(k));
        chk(cap_valid8 && cap_word8 == {wexp(k) ^ 4'hA, wexp(k)}, "R9 wide word",
            cap_word8, {wexp(k) ^ 4'hA, wexp(k)});
        src_w = wexp(k + 1);
      end
    end
    go = 1'b0;
    repeat (80) @(negedge clk);
    chk(cap_seen == n, "R6 each word exactly once", cap_seen, n);
    chk(order_err == 0, "R2 flag rise order", order_err, 0);
    chk(rel_err == 0, "R5 server release order", rel_err, 0);
    chk(timing_err == 0, "R4 capture timing", timing_err, 0);
    chk(min_cli_hi >= 2 * effc, "R7 client flag pulse", min_cli_hi, 2 * effc);
    chk(min_srv_hi >= effs + 1, "R7 server flag pulse", min_srv_hi, effs + 1);
    if (n > 1) chk(min_srv_lo >= 2 * effs, "R7 server flag gap", min_srv_lo, 2 * effs);
  endtask

  task automatic t_hold_zero();
    int c0, c1;
    run_words(4, 4'd0, 4'd0, c0);
    run_words(4, 4'd1, 4'd1, c1);
    chk(c0 == c1, "R10 hold zero matches hold one", c0, c1);
  endtask

  task automatic t_go_gate();
    int hi = 0;
    int vals = 0;
    int w = 0;
    do_reset();
    sh = 4'd1; ch = 4'd1;
    src_w = wexp(0);
    repeat (40) begin
      @(negedge clk);
      if (srv_rdy) hi++;
      if (cap_valid) vals++;
    end
    chk(hi == 0, "R8 server idle while disabled", hi, 0);
    chk(vals == 0, "R8 no capture while disabled", vals, 0);
    chk(cli_rdy == 1'b1, "R2 R8 client arms while disabled", cli_rdy, 1);
    go = 1'b1;
    do begin
      @(negedge clk);
      w++;
    end while (!cap_valid && w < 200);
    chk(cap_valid && cap_word == wexp(0), "R8 transfer resumes", cap_word, wexp(0));
    go = 1'b0;
    repeat (20) @(negedge clk);
  endtask

  task automatic t_midrun_reset();
    int w = 0;
    do_reset();
    sh = 4'd3; ch = 4'd3;
    src_w = wexp(0);
    go = 1'b1;
    do begin
      @(negedge clk);
      w++;
    end while (!cap_valid && w < 300);
    chk(cap_valid && cap_word == wexp(0), "R6 first word before reset", cap_word, wexp(0));
    src_w = wexp(1);
    w = 0;
    do begin
      @(negedge clk);
      w++;
    end while (!(srv_rdy && cli_rdy) && w < 300);
    chk(srv_rdy && cli_rdy, "R1 handshake reached before reset", {srv_rdy, cli_rdy}, 3);
    rst = 1'b1;
    @(negedge clk);
    chk(!srv_rdy && !cli_rdy && !cap_valid, "R1 flags cleared mid-transfer",
        {srv_rdy, cli_rdy, cap_valid}, 0);
    chk(cap_word == 4'd0, "R1 word cleared mid-transfer", cap_word, 0);
    go = 1'b0;
    rst = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    int c;
    do_reset();
    run_words(8, 4'd1, 4'd1, c);
    run_words(6, 4'd5, 4'd2, c);
    run_words(5, 4'd1, 4'd9, c);
    run_words(5, 4'd7, 4'd1, c);
    run_words(3, 4'd15, 4'd15, c);
    t_hold_zero();
    t_go_gate();
    t_midrun_reset();
    finish_run();
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R6 watchdog: actual=running expected=finished");
    finish_run();
  end
endmodule